// File: doc/BRIEF.md
# Edge-Capturing GPIO Port

This block is a 32-pin general-purpose I/O port behind a small synchronous register bus. Software picks, per pin, whether the pin drives or listens, whether a driving pin is push-pull or open-drain, and what output value it holds. The pad is modelled as separate output-enable and output-value vectors plus an input vector. Pad inputs pass through a synchronizer. Edges on the synchronized inputs are latched into a pending-event register. Software clears that register by writing ones to it. The pending events, gated by a per-pin mask, are ORed into a single interrupt line.

Edge selection has two build-time variants. In the compact variant each pin has one control bit that chooses between falling edges only and both edges. In the extended variant each pin has a two-bit code, and the codes are split across two control words. A parameter can also lock chosen pins to input.

The bus decodes a byte address. A write takes effect on the clock edge where write enable is high. Read data is registered: it is valid from the cycle after read enable is high and holds until the next read.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After a synchronous reset every register reads zero, the interrupt output is low and no pad output enable is active.
- R2: Byte offsets select the registers: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C pending events, 0x10 mask, 0x14 first edge control, 0x18 second edge control. Direction, open-drain, mask and both control words read back the last value written, and read data appears one cycle after read enable.
- R3: Pin n is bit 31−n of every register, so pin 0 is the most significant bit. Pad vectors are indexed by pin number.
- R4: In the event register, writing 1 to a bit clears that pending event and writing 0 leaves it as it was.
- R5: The interrupt output is high in the cycle after the AND of events and mask is nonzero, and low in the cycle after it is zero. A mask bit of 1 enables its pin.
- R6: In the compact variant, a control bit of 1 records only falling edges for its pin and a 0 records both edges. An event bit changes only on a recorded edge or on a clearing write.
- R7: In the extended variant, pins 0 to 15 take a two-bit code from the first control word at bit (15−p)·2, and pins 16 to 31 from the second word at bit (15−(p mod 16))·2. Code 00 records both edges, 01 rising edges, 10 falling edges and 11 no edge.
- R8: A data read returns the synchronized pad level for input pins and the held output value for output pins, whatever the pad shows.
- R9: On pins that the input-only parameter marks, a direction write of 1 is ignored: the bit reads 0 and the pad is never enabled.
- R10: If an edge is recorded on a pin in the same cycle as a clearing write to that pin's event bit, the bit stays set.
- R11: With the open-drain bit set on an output pin, the pad is enabled only while the held value is 0 and is released while the value is 1.
- R12: A push-pull output pin (direction 1, open-drain 0) has its pad enabled, and the pad value equals the held data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | NPINS | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | NPINS | Registered read data |
| pad_in | input | NPINS | Pad input levels, indexed by pin |
| pad_oe | output | NPINS | Pad output enables, indexed by pin |
| pad_out | output | NPINS | Pad output values, indexed by pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every pin through rising and falling edges under two opposite sets of edge-control values, in both variants at once. This exposes a field taken from the wrong word, a reversed bit order, or a swapped rising and falling code: each of these puts an event on the wrong bit or loses it. It makes a clearing write land on the exact cycle an edge is recorded, so a design that lets the clear win drops an interrupt. It also checks that a partial clear leaves the other pending bits in place. It drives pad levels that disagree with the held values on output pins, which catches a data read taken from the pad. It tries to turn input-only pins into outputs, and it checks open-drain release, where a design would otherwise drive a high level onto a shared line.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_ODR  = 3'd1,
    SEL_DAT  = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_MSK  = 3'd4,
    SEL_CTL  = 3'd5,
    SEL_CTL2 = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    SENSE_BOTH = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_OFF  = 2'b11
  } sense_code_e;

  localparam int WORD_SHIFT = 2;
  localparam int NUM_REGS   = 7;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev_q;
  assign fall = ~stg[STAGES-1] & prev_q;

endmodule

// File: rtl/gpio_sense_sel.sv
module gpio_sense_sel
  import gpio_edge_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter bit EXT_SENSE = 1'b0
) (
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  input  logic [NPINS-1:0] ctl,
  input  logic [NPINS-1:0] ctl2,
  output logic [NPINS-1:0] rec
);

  localparam int HALF = NPINS / 2;

  generate
    if (EXT_SENSE) begin : g_ext
      for (genvar b = 0; b < NPINS; b++) begin : g_bit
        localparam int PIN = NPINS - 1 - b;
        logic [1:0] code;
        if (PIN < HALF) begin : g_lo
          assign code = ctl[(HALF-1-PIN)*2 +: 2];
        end else begin : g_hi
          assign code = ctl2[(HALF-1-(PIN-HALF))*2 +: 2];
        end
        always_comb begin
          unique case (sense_code_e'(code))
            SENSE_BOTH: rec[b] = rise[b] | fall[b];
            SENSE_RISE: rec[b] = rise[b];
            SENSE_FALL: rec[b] = fall[b];
            default:    rec[b] = 1'b0;
          endcase
        end
      end
    end else begin : g_cmp
      logic [NPINS-1:0] unused_ctl2;
      assign unused_ctl2 = ctl2;
      assign rec = fall | (rise & ~ctl);
    end
  endgenerate

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int               NPINS       = 32,
  parameter int               ADDR_W      = 5,
  parameter int               SYNC_STAGES = 2,
  parameter bit               EXT_SENSE   = 1'b0,
  parameter logic [NPINS-1:0] INPUT_ONLY  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wdata,
  input  logic              rd_en,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic              irq
);

  localparam int WORD_W = ADDR_W - WORD_SHIFT;

  logic [NPINS-1:0] dir_q, odr_q, dat_q, evt_q, msk_q, ctl_q, ctl2_q;
  logic [NPINS-1:0] rdata_q, oe_q, out_q;
  logic             irq_q;
  logic [NPINS-1:0] in_bits, lock_bits;
  logic [NPINS-1:0] lvl, rise, fall, rec;
  logic [NPINS-1:0] evt_clr, evt_nxt, data_view;
  logic [WORD_W-1:0] word;
  reg_sel_e         sel;
  logic             wr_evt;

  // pin n <-> register bit NPINS-1-n
  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign in_bits[NPINS-1-p]   = pad_in[p];
      assign lock_bits[NPINS-1-p] = INPUT_ONLY[p];
      assign pad_oe[p]            = oe_q[NPINS-1-p];
      assign pad_out[p]           = out_q[NPINS-1-p];
    end
  endgenerate

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (in_bits),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  gpio_sense_sel #(.NPINS(NPINS), .EXT_SENSE(EXT_SENSE)) u_sense (
    .rise (rise),
    .fall (fall),
    .ctl  (ctl_q),
    .ctl2 (ctl2_q),
    .rec  (rec)
  );

  always_comb begin
    word = addr[ADDR_W-1:WORD_SHIFT];
    if ((addr[WORD_SHIFT-1:0] == '0) && (word < WORD_W'(NUM_REGS)))
      sel = reg_sel_e'(word[2:0]);
    else
      sel = SEL_NONE;
  end

  assign wr_evt    = wr_en && (sel == SEL_EVT);
  assign evt_clr   = wr_evt ? wdata : '0;
  assign evt_nxt   = (evt_q & ~evt_clr) | rec;
  assign data_view = (lvl & ~dir_q) | (dat_q & dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      odr_q  <= '0;
      dat_q  <= '0;
      msk_q  <= '0;
      ctl_q  <= '0;
      ctl2_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_DIR:  dir_q  <= wdata & ~lock_bits;
        SEL_ODR:  odr_q  <= wdata;
        SEL_DAT:  dat_q  <= wdata;
        SEL_MSK:  msk_q  <= wdata;
        SEL_CTL:  ctl_q  <= wdata;
        SEL_CTL2: ctl2_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      unique case (sel)
        SEL_DIR:  rdata_q <= dir_q;
        SEL_ODR:  rdata_q <= odr_q;
        SEL_DAT:  rdata_q <= data_view;
        SEL_EVT:  rdata_q <= evt_q;
        SEL_MSK:  rdata_q <= msk_q;
        SEL_CTL:  rdata_q <= ctl_q;
        SEL_CTL2: rdata_q <= ctl2_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      oe_q  <= '0;
      out_q <= '0;
    end else begin
      irq_q <= |(evt_q & msk_q);
      oe_q  <= dir_q & ~(odr_q & dat_q);
      out_q <= dat_q;
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             wr_evt,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] rec,
  input logic [NPINS-1:0] evt_q,
  input logic [NPINS-1:0] msk_q,
  input logic [NPINS-1:0] odr_q,
  input logic [NPINS-1:0] oe_q,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] lock_bits
);

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(evt_q & msk_q)) |=> irq); // R5
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    !(|(evt_q & msk_q)) |=> !irq); // R5
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> ((evt_q & $past(wdata & ~rec)) == '0)); // R4
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (rec != '0) |=> ((evt_q & $past(rec)) == $past(rec))); // R10
  AST_EVT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wr_evt && rec == '0) |=> $stable(evt_q)); // R6
  AST_LOCKED_PIN: assert property (@(posedge clk) disable iff (rst)
    (oe_q & lock_bits) == '0); // R9
  AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (oe_q & out_q & $past(odr_q)) == '0); // R11

endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .wr_evt    (wr_evt),
  .wdata     (wdata),
  .rec       (rec),
  .evt_q     (evt_q),
  .msk_q     (msk_q),
  .odr_q     (odr_q),
  .oe_q      (oe_q),
  .out_q     (out_q),
  .lock_bits (lock_bits)
);

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;

  localparam logic [31:0] LOCK_PINS = 32'h0000_000F; // pins 0..3 input-only on u0
  localparam logic [31:0] LOCK_BITS = 32'hF000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata0, rdata1, oe0, oe1, out0, out1;
  logic        irq0, irq1;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_ctrl #(.EXT_SENSE(1'b0), .INPUT_ONLY(LOCK_PINS)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata0), .pad_in(pad_in), .pad_oe(oe0),
    .pad_out(out0), .irq(irq0));

  gpio_edge_ctrl #(.EXT_SENSE(1'b1)) u1 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata1), .pad_in(pad_in), .pad_oe(oe1),
    .pad_out(out1), .irq(irq1));

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[i] = v[31-i];
  endfunction

  function automatic bit exp_cmp(input int p, input logic [31:0] c, input bit rising);
    return rising ? !c[31-p] : 1'b1;
  endfunction

  function automatic bit exp_ext(input int p, input logic [31:0] c1, input logic [31:0] c2,
                                 input bit rising);
    logic [1:0] code;
    code = (p < 16) ? c1[(15-p)*2 +: 2] : c2[(15-(p-16))*2 +: 2];
    case (code)
      2'b00:   return 1'b1;
      2'b01:   return rising;
      2'b10:   return !rising;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] c1, c2, dir_v, dat_v, pin_v, exp0, exp1;
    idle(4);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values on every register and output
    for (int r = 0; r < 7; r++) begin
      rd(5'(r * 4));
      check("R1 u0 reg", rdata0, 32'h0);
      check("R1 u1 reg", rdata1, 32'h0);
    end
    check("R1 irq", {30'h0, irq1, irq0}, 32'h0);
    check("R1 u0 oe", oe0, 32'h0);
    check("R1 u1 oe", oe1, 32'h0);

    // R2: readback of plain registers at their offsets
    wr(5'h00, 32'h1234_5678); wr(5'h04, 32'h9ABC_DEF0); wr(5'h10, 32'h0F1E_2D3C);
    wr(5'h14, 32'hCAFE_0011); wr(5'h18, 32'h5500_AA77);
    rd(5'h00); check("R2 u1 dir", rdata1, 32'h1234_5678);
    check("R9 u0 dir locked", rdata0, 32'h1234_5678 & ~LOCK_BITS);
    rd(5'h04); check("R2 u1 odr", rdata1, 32'h9ABC_DEF0);
    rd(5'h10); check("R2 u1 msk", rdata1, 32'h0F1E_2D3C);
    rd(5'h14); check("R2 u1 ctl", rdata1, 32'hCAFE_0011);
    rd(5'h18); check("R2 u1 ctl2", rdata1, 32'h5500_AA77);
    wr(5'h10, 32'h0);

    // R8, R12, R3: data view and push-pull pads
    dir_v = 32'hFFFF_0000; dat_v = 32'hA5A5_C3C3; pin_v = 32'h0F0F_3355;
    wr(5'h04, 32'h0); wr(5'h00, dir_v); wr(5'h08, dat_v);
    pad_in = pin_v;
    idle(5);
    rd(5'h08);
    check("R8 u1 data", rdata1, (rev(pin_v) & ~dir_v) | (dat_v & dir_v));
    check("R8 u0 data", rdata0, (rev(pin_v) & ~(dir_v & ~LOCK_BITS)) | (dat_v & dir_v & ~LOCK_BITS));
    check("R12 u1 oe", oe1, rev(dir_v));
    check("R12 u1 out", out1, rev(dat_v));
    check("R9 u0 oe locked", oe0, rev(dir_v & ~LOCK_BITS));

    // R11: open drain releases high outputs
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'hFFFF_FFFF);
    idle(2);
    check("R11 u1 oe", oe1, rev(~dat_v));
    check("R11 u0 oe", oe0, rev(~dat_v & ~LOCK_BITS));
    check("R9 u0 oe pins0-3", oe0 & LOCK_PINS, 32'h0);

    // quiet state before event tests
    wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h08, 32'h0);
    pad_in = '0;
    idle(5);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C);
    check("R4 clear all", rdata0 | rdata1, 32'h0);

    // R3, R6, R7: per-pin edge sweep, two opposite control settings
    for (int pass = 0; pass < 2; pass++) begin
      c1 = pass ? 32'hE4E4_E4E4 : 32'h1B1B_1B1B;
      c2 = pass ? 32'h1B1B_1B1B : 32'hE4E4_E4E4;
      wr(5'h14, c1); wr(5'h18, c2);
      for (int p = 0; p < 32; p++) begin
        for (int e = 0; e < 2; e++) begin
          pad_in[p] = (e == 0);
          idle(4);
          rd(5'h0C);
          exp0 = exp_cmp(p, c1, e == 0) ? (32'h8000_0000 >> p) : 32'h0;
          exp1 = exp_ext(p, c1, c2, e == 0) ? (32'h8000_0000 >> p) : 32'h0;
          check("R6 R3 u0 edge", rdata0, exp0);
          check("R7 R3 u1 edge", rdata1, exp1);
          wr(5'h0C, 32'hFFFF_FFFF);
        end
      end
    end

    // R5, R4: masking and partial clear
    wr(5'h14, 32'h0); wr(5'h18, 32'h0); wr(5'h10, 32'h0);
    pad_in[5] = 1'b1; pad_in[9] = 1'b1;
    idle(5);
    check("R5 masked irq low", {31'h0, irq0}, 32'h0);
    wr(5'h10, 32'h0400_0000);
    idle(2);
    check("R5 irq high", {31'h0, irq0}, 32'h1);
    wr(5'h0C, 32'h0400_0000);
    rd(5'h0C);
    check("R4 partial clear", rdata0, 32'h0040_0000);
    check("R4 partial clear ext", rdata1, 32'h0040_0000);
    idle(1);
    check("R5 irq low after clear", {31'h0, irq0}, 32'h0);
    wr(5'h10, 32'h0);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R10: clearing write lands on the cycle an edge is recorded
    pad_in[7] = 1'b1;
    idle(5);
    pad_in[7] = 1'b0;
    idle(2);
    wr(5'h0C, 32'h0100_0000);
    idle(3);
    rd(5'h0C);
    check("R10 u0 edge wins", rdata0, 32'h0100_0000);
    check("R10 u1 edge wins", rdata1, 32'h0100_0000);
    wr(5'h0C, 32'h0100_0000);
    rd(5'h0C);
    check("R4 later clear", rdata0 | rdata1, 32'h0);

    finish_run();
  end

endmodule